// File: doc/BRIEF.md
# Sized Shift Unit with Condition Flags

This block is the shift stage of a processor's integer pipeline. Each accepted request carries a 32-bit operand, an operand size (byte, word or long), a 6-bit shift count, a direction select, a shift-type select and the current extend flag. The stage shifts only the low part of the operand that the size selects. It returns the shifted value with the untouched upper bits merged back in, together with the negative, zero, overflow, carry and extend flags.

Results are registered. They appear, with a one-cycle valid pulse, on the clock edge after the request strobe. Arithmetic left shifts report overflow when any bit that moves through the sign position differs from the original sign bit, not only the last one. Each of four count ranges (zero, inside the width, equal to the width, past the width) has its own carry and result rule.

Top module: `shift_cc_unit`

## Requirements
- R1: `out_valid` is high on the cycle after each cycle with `in_valid` high, and low after each cycle with `in_valid` low; the result and flags are captured only on a request.
- R2: `op_size` 2'b00 selects 8 bits, 2'b01 selects 16 bits, and 2'b10 or 2'b11 selects 32 bits. Result bits above the selected size equal the operand's bits.
- R3: With a count of zero, the sized result equals the operand, C and V are 0, and X equals `x_in`.
- R4: A left shift (`dir_left`=1) by a count c with 0<c<w gives the operand shifted left by c within w bits, and C equals operand bit w−c.
- R5: A left shift by c=w gives a zero result with C equal to operand bit 0. A left shift by c>w gives a zero result with C equal to 0.
- R6: An arithmetic left shift (`logical`=0) by 0<c<w sets V unless operand bits w−1 down to w−1−c are all equal.
- R7: An arithmetic left shift by c≥w sets V exactly when the sized operand is nonzero.
- R8: A logical right shift by 0<c<w gives zero fill with C equal to operand bit c−1. At c=w the result is zero and C equals bit w−1. For c>w the result and C are zero.
- R9: An arithmetic right shift by 0<c<w fills with the sign bit, and C equals operand bit c−1. For c≥w every sized bit and C equal the sign bit.
- R10: V is 0 for every logical shift and every right shift.
- R11: N equals bit w−1 of the sized result, and Z is 1 exactly when the sized result is zero.
- R12: For a nonzero count, X equals the new C.
- R13: A synchronous active-high reset clears `out_valid`, the result and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| operand | input | 32 | Value to shift |
| op_size | input | 2 | Operand size select |
| shift_cnt | input | 6 | Shift count, 0 to 63 |
| dir_left | input | 1 | 1 = shift left, 0 = shift right |
| logical | input | 1 | 1 = logical, 0 = arithmetic |
| x_in | input | 1 | Current extend flag |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Shifted value with upper bits passed through |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| flag_x | output | 1 | Extend flag |

## Verification
Every count from 0 to 63 is swept for all sizes, both directions and both shift types. The sweep uses operands chosen to separate the cases:
- a lone sign bit, where left-shift overflow appears at count 1;
- a sign bit followed by a run of equal bits, where overflow appears only once the run is exhausted;
- all ones and zero, where overflow must never appear;
- a lone bit 0, which tells the count-equals-width carry from the count-above-width carry;
- mixed patterns whose upper bytes expose a faulty pass-through.

Pseudo-random requests, including idle cycles between requests, then separate the registered valid timing and the X hold on zero counts from the shift logic itself.

// File: rtl/shcc_pkg.sv
package shcc_pkg;

    localparam int SHCC_DATA_W = 32;
    localparam int SHCC_CNT_W  = 6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_ALT  = 2'b11
    } opsize_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
        logic x;
    } ccr_t;

    // Number of active bits for a size code.
    function automatic int size_bits(input logic [1:0] sz, input int data_w);
        case (sz)
            SZ_BYTE: size_bits = data_w / 4;
            SZ_WORD: size_bits = data_w / 2;
            default: size_bits = data_w;
        endcase
    endfunction

    // Mask with the low w bits set.
    function automatic logic [SHCC_DATA_W-1:0] low_mask(input int w);
        logic [SHCC_DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < SHCC_DATA_W; i++) begin
            if (i < w) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/shcc_left.sv
module shcc_left #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    localparam int WID_W = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] op_sized,
    input  logic [WID_W-1:0]  width,
    input  logic [CNT_W-1:0]  count,
    input  logic              logical,
    output logic [DATA_W-1:0] res,
    output logic              carry,
    output logic              ovf
);
    int  w;
    int  c;
    logic all_one;
    logic all_zero;

    always_comb begin
        w        = int'(width);
        c        = int'(count);
        res      = '0;
        carry    = 1'b0;
        ovf      = 1'b0;
        all_one  = 1'b1;
        all_zero = 1'b1;
        if (c == 0) begin
            res = op_sized;
        end else if (c < w) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (i >= c && i < w) res[i] = op_sized[i-c];
            end
            carry = op_sized[w-c];
            // Bits that pass through the sign position.
            for (int i = 0; i < DATA_W; i++) begin
                if (i >= w - 1 - c && i < w) begin
                    if (op_sized[i]) all_zero = 1'b0;
                    else             all_one  = 1'b0;
                end
            end
            ovf = !(all_one || all_zero);
        end else begin
            res   = '0;
            carry = (c == w) ? op_sized[0] : 1'b0;
            ovf   = (op_sized != '0);
        end
        if (logical) ovf = 1'b0;
    end

endmodule

// File: rtl/shcc_right.sv
module shcc_right #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    localparam int WID_W = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] op_sized,
    input  logic [WID_W-1:0]  width,
    input  logic [CNT_W-1:0]  count,
    input  logic              logical,
    output logic [DATA_W-1:0] res,
    output logic              carry
);
    int   w;
    int   c;
    logic fill;

    always_comb begin
        w     = int'(width);
        c     = int'(count);
        fill  = logical ? 1'b0 : op_sized[w-1];
        res   = '0;
        carry = 1'b0;
        if (c == 0) begin
            res = op_sized;
        end else if (c < w) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (i < w) res[i] = (i + c < w) ? op_sized[i+c] : fill;
            end
            carry = op_sized[c-1];
        end else begin
            for (int i = 0; i < DATA_W; i++) begin
                if (i < w) res[i] = fill;
            end
            if (logical) carry = (c == w) ? op_sized[w-1] : 1'b0;
            else         carry = fill;
        end
    end

endmodule

// File: rtl/shcc_flags.sv
module shcc_flags #(
    parameter int DATA_W = 32,
    localparam int WID_W = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] res_sized,
    input  logic [WID_W-1:0]  width,
    output logic [DATA_W-1:0] merged,
    output logic              neg,
    output logic              zero
);
    int w;

    always_comb begin
        w      = int'(width);
        merged = operand;
        zero   = 1'b1;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < w) begin
                merged[i] = res_sized[i];
                if (res_sized[i]) zero = 1'b0;
            end
        end
        neg = res_sized[w-1];
    end

endmodule

// File: rtl/shift_cc_unit.sv
module shift_cc_unit
    import shcc_pkg::*;
#(
    parameter int DATA_W = SHCC_DATA_W,
    parameter int CNT_W  = SHCC_CNT_W,
    localparam int WID_W = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic [1:0]        op_size,
    input  logic [CNT_W-1:0]  shift_cnt,
    input  logic              dir_left,
    input  logic              logical,
    input  logic              x_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              flag_x
);
    logic [WID_W-1:0]  width;
    logic [DATA_W-1:0] op_sized;
    logic [DATA_W-1:0] l_res, r_res, sel_res, merged;
    logic              l_c, l_v, r_c, neg, zero;
    ccr_t              ccr_d, ccr_q;
    logic [DATA_W-1:0] res_q;
    logic              vld_q;

    always_comb begin
        width = '0;
        op_sized = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < size_bits(op_size, DATA_W)) op_sized[i] = operand[i];
        end
        width = WID_W'(size_bits(op_size, DATA_W));
    end

    shcc_left #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_left (
        .op_sized (op_sized),
        .width    (width),
        .count    (shift_cnt),
        .logical  (logical),
        .res      (l_res),
        .carry    (l_c),
        .ovf      (l_v)
    );

    shcc_right #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_right (
        .op_sized (op_sized),
        .width    (width),
        .count    (shift_cnt),
        .logical  (logical),
        .res      (r_res),
        .carry    (r_c)
    );

    assign sel_res = dir_left ? l_res : r_res;

    shcc_flags #(.DATA_W(DATA_W)) u_flags (
        .operand   (operand),
        .res_sized (sel_res),
        .width     (width),
        .merged    (merged),
        .neg       (neg),
        .zero      (zero)
    );

    always_comb begin
        ccr_d.n = neg;
        ccr_d.z = zero;
        ccr_d.v = dir_left ? l_v : 1'b0;
        ccr_d.c = dir_left ? l_c : r_c;
        ccr_d.x = (shift_cnt != '0) ? ccr_d.c : x_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
            ccr_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= merged;
                ccr_q <= ccr_d;
            end
        end
    end

    assign out_valid = vld_q;
    assign result    = res_q;
    assign flag_n    = ccr_q.n;
    assign flag_z    = ccr_q.z;
    assign flag_v    = ccr_q.v;
    assign flag_c    = ccr_q.c;
    assign flag_x    = ccr_q.x;

endmodule

// File: rtl/shcc_checker.sv
module shcc_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    localparam int BYTE_W = DATA_W / 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] operand,
    input logic [1:0]        op_size,
    input logic [CNT_W-1:0]  shift_cnt,
    input logic              dir_left,
    input logic              logical,
    input logic              x_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              flag_v,
    input logic              flag_c,
    input logic              flag_x
);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    byte_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_size == 2'b00) |=>
            result[DATA_W-1:BYTE_W] == $past(operand[DATA_W-1:BYTE_W]));

    // R3
    zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shift_cnt == '0) |=>
            (!flag_c && !flag_v && flag_x == $past(x_in)));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (logical || !dir_left)) |=> !flag_v);

    // R12
    x_tracks_c_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shift_cnt != '0) |=> flag_x == flag_c);

    // R13
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !flag_x && !flag_c && result == '0));

endmodule

bind shift_cc_unit shcc_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .operand   (operand),
    .op_size   (op_size),
    .shift_cnt (shift_cnt),
    .dir_left  (dir_left),
    .logical   (logical),
    .x_in      (x_in),
    .out_valid (out_valid),
    .result    (result),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .flag_x    (flag_x)
);

// File: tb/shift_cc_unit_test.sv
module shift_cc_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  op_size = '0;
    logic [5:0]  shift_cnt = '0;
    logic        dir_left = 1'b0;
    logic        logical = 1'b0;
    logic        x_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c, flag_x;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    shift_cc_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .op_size(op_size), .shift_cnt(shift_cnt), .dir_left(dir_left),
        .logical(logical), .x_in(x_in), .out_valid(out_valid),
        .result(result), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .flag_x(flag_x)
    );

    // Expected values of the previous request.
    bit          pend = 0;
    logic [31:0] e_res;
    logic        e_n, e_z, e_v, e_c, e_x;
    string       t_res, t_c, t_v, t_x;
    int          e_w;
    logic [31:0] e_op;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural model computed from the requirements.
    task automatic model(input logic [31:0] op, input logic [1:0] sz, input int c,
                         input bit left, input bit lg, input bit xi);
        logic [63:0] mask, val, r, top, ones;
        logic signed [63:0] s;
        int w;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        mask = (64'd1 << w) - 1;
        val  = {32'd0, op} & mask;
        e_v  = 0;
        e_c  = 0;
        if (c == 0) begin
            r = val; t_res = "R3"; t_c = "R3"; t_v = "R3";
        end else if (left) begin
            r = (val << c) & mask;
            t_res = (c < w) ? "R4" : "R5"; t_c = t_res;
            e_c = (c <= w) ? val[w-c] : 1'b0;
            t_v = lg ? "R10" : (c < w) ? "R6" : "R7";
            if (!lg) begin
                if (c >= w) e_v = (val != 0);
                else begin
                    top  = val >> (w - 1 - c);
                    ones = (64'd1 << (c + 1)) - 1;
                    e_v  = (top != 0) && (top != ones);
                end
            end
        end else begin
            t_v = "R10";
            if (lg) begin
                r = val >> c; t_res = "R8"; t_c = "R8";
                e_c = (c <= w) ? val[c-1] : 1'b0;
            end else begin
                s = val[w-1] ? $signed(val | ~mask) : $signed(val);
                r = 64'(s >>> c) & mask; t_res = "R9"; t_c = "R9";
                e_c = (c < w) ? val[c-1] : val[w-1];
            end
        end
        e_res = (op & ~mask[31:0]) | r[31:0];
        e_n   = r[w-1];
        e_z   = (r == 0);
        e_x   = (c != 0) ? e_c : xi;
        t_x   = (c != 0) ? "R12" : "R3";
        e_w   = w;
        e_op  = op;
    endtask

    task automatic compare();
        check("R1 out_valid", out_valid, pend);
        if (pend) begin
            logic [31:0] um;
            um = (e_w == 32) ? 32'd0 : ~((32'd1 << e_w) - 1);
            check({t_res, " result"}, result & ~um, e_res & ~um);
            check("R2 upper bits", result & um, e_op & um);
            check({t_c, " C"}, flag_c, e_c);
            check({t_v, " V"}, flag_v, e_v);
            check("R11 N", flag_n, e_n);
            check("R11 Z", flag_z, e_z);
            check({t_x, " X"}, flag_x, e_x);
        end
    endtask

    // Called at a negedge: check previous, drive new.
    task automatic step(input bit v, input logic [31:0] op, input logic [1:0] sz,
                        input int c, input bit left, input bit lg, input bit xi);
        compare();
        in_valid = v; operand = op; op_size = sz; shift_cnt = 6'(c);
        dir_left = left; logical = lg; x_in = xi;
        pend = v;
        if (v) model(op, sz, c, left, lg, xi);
        @(negedge clk);
    endtask

    logic [31:0] pats [8] = '{32'h0000_0080, 32'h0000_C000, 32'hFFFF_FFFF,
                              32'h0000_0000, 32'h0000_0001, 32'h8000_0000,
                              32'hA5C3_1E7F, 32'h3C00_7F40};

    initial begin
        logic [31:0] lfsr;
        @(negedge clk);
        @(negedge clk);
        // R13: outputs clear under reset
        check("R13 out_valid", out_valid, 0);
        check("R13 result", result, 0);
        check("R13 X", flag_x, 0);
        check("R13 C", flag_c, 0);
        rst = 0;
        for (int p = 0; p < 8; p++)
            for (int sz = 0; sz < 4; sz++)
                for (int m = 0; m < 4; m++)
                    for (int c = 0; c < 64; c++)
                        step(1, pats[p] ^ (32'h1200_0000 * sz), 2'(sz), c,
                             m[1], m[0], c[0]);
        lfsr = 32'hACE1_2468;
        for (int k = 0; k < 6000; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[3:0] != 0, lfsr * 32'h9E37_79B9, lfsr[5:4],
                 int'(lfsr[11:6]) & ((lfsr[12]) ? 7 : 63), lfsr[13], lfsr[14], lfsr[15]);
        end
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        // R13: reset mid-run clears outputs
        rst = 1;
        @(negedge clk);
        check("R13 result after reset", result, 0);
        check("R13 X after reset", flag_x, 0);
        check("R13 valid after reset", out_valid, 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule